// File: doc/BRIEF.md
# Master/Slave Video Sync Generator

This block produces line and frame timing for a display pipeline. One pair of counters tracks the horizontal pixel position and the vertical line position. In master mode the counters run freely from programmed cycle lengths, and the block drives horizontal, vertical and composite sync pulses whose widths are also programmed. In slave mode the same counters follow external sync inputs. A falling edge on the external horizontal sync realigns the pixel counter, and a rising edge on the external vertical sync realigns the line counter. Between edges the counters keep running from the programmed lengths.

Two sticky flags, frame and vertical blank, are set when the line counter arrives at the programmed vertical sync start line. Software clears them by writing ones. For interlaced scanning the block either generates an odd/even field signal (master) or takes one in from the field pin (slave). The current pixel and line positions are exported so that a pixel fetch stage can follow them.

Top module: `vsync_gen`

## Requirements
- R1: Register port writes take effect on the next clock edge. The register at address 0 holds bit0 = slave mode and bit1 = interlace. After reset the block is in master mode without interlace, `hpos_o` and `vpos_o` are 0, and `frame_o`, `vblank_o`, `field_odd_o` and `field_oe_o` are 0.
- R2: In master mode `hpos_o` counts 0 to HCYC-1 (HCYC at address 2) and then wraps. `hsync_o` is low for HWID clocks (HWID at address 1), starting in the cycle in which `hpos_o` is 0, and repeats every HCYC clocks.
- R3: In master mode `vpos_o` advances once per line and wraps after VCYC lines (VCYC at address 4). `vsync_o` goes low when `vpos_o` becomes VSP (VSP at address 5) and stays low for VWID lines (VWID at address 3). This assumes VSP+VWID <= VCYC.
- R4: In master mode `csync_o` is low whenever `hsync_o` or `vsync_o` is low, and high otherwise.
- R5: In both modes, `frame_o` and `vblank_o` are set in the cycle in which `vpos_o` first takes the value VSP. They stay set until cleared.
- R6: A write to address 6 clears `frame_o` if bit0 of the data is 1 and clears `vblank_o` if bit1 is 1. A flag whose data bit is 0 is left unchanged.
- R7: In slave mode, a falling edge on `ext_hsync_i` sets `hpos_o` to 0. The value 0 is visible after the second clock edge following the edge that first samples the new level. A rising edge on `ext_hsync_i` has no effect.
- R8: In slave mode, a rising edge on `ext_vsync_i` sets `vpos_o` to 0 with the same latency as R7. A falling edge on `ext_vsync_i` has no effect.
- R9: In slave mode `csync_o`, `hsync_o` and `vsync_o` are held high.
- R10: In master mode with interlace, `field_oe_o` is high and `field_o` equals `field_odd_o`. `field_odd_o` toggles each time `vpos_o` reaches VSP.
- R11: In slave mode with interlace, `field_oe_o` is low and `field_odd_o` follows `field_i` after a two-flop synchronizer. It shows the new level after the second clock edge.
- R12: Without interlace, `field_odd_o` and `field_oe_o` stay low in both modes, and `field_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | HCNT_W | Register write data |
| ext_hsync_i | input | 1 | External horizontal sync, line starts on falling edge |
| ext_vsync_i | input | 1 | External vertical sync, frame starts on rising edge |
| field_i | input | 1 | External odd/even field level |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| csync_o | output | 1 | Composite sync, active low |
| field_o | output | 1 | Generated field level |
| field_oe_o | output | 1 | Enable for driving field_o onto the field pin |
| field_odd_o | output | 1 | Field in effect (1 = odd) |
| frame_o | output | 1 | Sticky frame flag |
| vblank_o | output | 1 | Sticky vertical blank flag |
| hpos_o | output | HCNT_W | Pixel position within the line |
| vpos_o | output | VCNT_W | Line position within the frame |

## Verification
Master-mode pulses and the flags come straight from the counter registers, so they change on the same edge as the positions. The bench therefore measures pulse widths and periods in whole clocks between observed edges, and checks the flags in the first sample that shows `vpos_o` equal to VSP. The slave-mode inputs pass through two synchronizer flops, and the edge detector adds one more register. The bench drives each external edge just after a falling clock edge and samples positions on the third falling edge after that, and the field level on the second. Register writes are checked one cycle after the write edge.

// File: rtl/vsync_pkg.sv
package vsync_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_HWID = 3'd1,
    REG_HCYC = 3'd2,
    REG_VWID = 3'd3,
    REG_VCYC = 3'd4,
    REG_VSP  = 3'd5,
    REG_STAT = 3'd6
  } reg_addr_e;

  localparam int unsigned CTRL_SLAVE_BIT = 0;
  localparam int unsigned CTRL_ILACE_BIT = 1;
  localparam int unsigned STAT_FRAME_BIT = 0;
  localparam int unsigned STAT_VBLK_BIT  = 1;
endpackage

// File: rtl/vsync_sync2.sv
module vsync_sync2 #(
  parameter int unsigned       W       = 1,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/vsync_hcnt.sv
module vsync_hcnt #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         realign_i,
  input  logic [W-1:0] cyc_i,
  input  logic [W-1:0] wid_i,
  output logic [W-1:0] cnt_o,
  output logic         line_start_o,
  output logic         act_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (realign_i)                cnt_d = '0;
    else if (cnt_q >= cyc_i - ONE) cnt_d = '0;
    else                           cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // a realign on a counter already at 0 does not start a second line
  assign line_start_o = (cnt_d == '0) && (cnt_q != '0);
  assign act_o        = cnt_q < wid_i;
  assign cnt_o        = cnt_q;

  // R2
  hcnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!realign_i && cyc_i != '0 && cnt_q == cyc_i - ONE) |=> (cnt_q == '0));
endmodule

// File: rtl/vsync_vcnt.sv
module vsync_vcnt #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         realign_i,
  input  logic         line_start_i,
  input  logic [W-1:0] cyc_i,
  input  logic [W-1:0] wid_i,
  input  logic [W-1:0] sp_i,
  output logic [W-1:0] cnt_o,
  output logic         vs_start_o,
  output logic         act_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   end_line;

  always_comb begin
    cnt_d = cnt_q;
    if (realign_i)                 cnt_d = '0;
    else if (line_start_i) begin
      if (cnt_q >= cyc_i - ONE)    cnt_d = '0;
      else                         cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign end_line   = {1'b0, sp_i} + {1'b0, wid_i};
  assign vs_start_o = (cnt_d == sp_i) && (cnt_d != cnt_q);
  assign act_o      = (cnt_q >= sp_i) && ({1'b0, cnt_q} < end_line);
  assign cnt_o      = cnt_q;

  // R3
  vcnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!realign_i && !line_start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/vsync_status.sv
module vsync_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vs_start_i,
  input  logic clr_frame_i,
  input  logic clr_vblk_i,
  input  logic slave_i,
  input  logic ilace_i,
  input  logic field_ext_i,
  output logic frame_o,
  output logic vblank_o,
  output logic field_gen_o,
  output logic field_odd_o,
  output logic field_oe_o
);
  logic frame_q, vblk_q, field_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= 1'b0;
      vblk_q  <= 1'b0;
      field_q <= 1'b0;
    end else begin
      // set has priority over clear
      if (vs_start_i)       frame_q <= 1'b1;
      else if (clr_frame_i) frame_q <= 1'b0;
      if (vs_start_i)       vblk_q  <= 1'b1;
      else if (clr_vblk_i)  vblk_q  <= 1'b0;
      if (!slave_i && ilace_i && vs_start_i) field_q <= ~field_q;
    end
  end

  assign frame_o     = frame_q;
  assign vblank_o    = vblk_q;
  assign field_gen_o = field_q;
  assign field_oe_o  = !slave_i && ilace_i;
  assign field_odd_o = !ilace_i ? 1'b0 : (slave_i ? field_ext_i : field_q);

  // R5
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_start_i |=> (frame_q && vblk_q));

  // R6
  frame_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_frame_i && !vs_start_i) |=> !frame_q);

  // R10
  field_tgl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_i && ilace_i && vs_start_i) |=> (field_q != $past(field_q)));
endmodule

// File: rtl/vsync_gen.sv
module vsync_gen
  import vsync_pkg::*;
#(
  parameter int unsigned HCNT_W   = 12,
  parameter int unsigned VCNT_W   = 11,
  parameter int unsigned HCYC_RST = 16,
  parameter int unsigned HWID_RST = 2,
  parameter int unsigned VCYC_RST = 8,
  parameter int unsigned VWID_RST = 1,
  parameter int unsigned VSP_RST  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [HCNT_W-1:0] cfg_wdata_i,
  input  logic              ext_hsync_i,
  input  logic              ext_vsync_i,
  input  logic              field_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              csync_o,
  output logic              field_o,
  output logic              field_oe_o,
  output logic              field_odd_o,
  output logic              frame_o,
  output logic              vblank_o,
  output logic [HCNT_W-1:0] hpos_o,
  output logic [VCNT_W-1:0] vpos_o
);
  // bit order of the synchronised bus: {field, vsync, hsync}
  localparam logic [2:0] SYNC_RST = 3'b001;

  logic              slave_q, ilace_q;
  logic [HCNT_W-1:0] hwid_q, hcyc_q;
  logic [VCNT_W-1:0] vwid_q, vcyc_q, vsp_q;
  logic              clr_frame, clr_vblk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slave_q <= 1'b0;
      ilace_q <= 1'b0;
      hwid_q  <= HCNT_W'(HWID_RST);
      hcyc_q  <= HCNT_W'(HCYC_RST);
      vwid_q  <= VCNT_W'(VWID_RST);
      vcyc_q  <= VCNT_W'(VCYC_RST);
      vsp_q   <= VCNT_W'(VSP_RST);
    end else if (cfg_we_i) begin
      case (reg_addr_e'(cfg_addr_i))
        REG_CTRL: begin
          slave_q <= cfg_wdata_i[CTRL_SLAVE_BIT];
          ilace_q <= cfg_wdata_i[CTRL_ILACE_BIT];
        end
        REG_HWID: hwid_q <= cfg_wdata_i;
        REG_HCYC: hcyc_q <= cfg_wdata_i;
        REG_VWID: vwid_q <= cfg_wdata_i[VCNT_W-1:0];
        REG_VCYC: vcyc_q <= cfg_wdata_i[VCNT_W-1:0];
        REG_VSP:  vsp_q  <= cfg_wdata_i[VCNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign clr_frame = cfg_we_i && (cfg_addr_i == REG_STAT) && cfg_wdata_i[STAT_FRAME_BIT];
  assign clr_vblk  = cfg_we_i && (cfg_addr_i == REG_STAT) && cfg_wdata_i[STAT_VBLK_BIT];

  // external inputs: synchronise, then detect edges
  logic [2:0] ext_lvl;
  logic       hs_prev_q, vs_prev_q;
  logic       hs_fall, vs_rise;

  vsync_sync2 #(.W(3), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({field_i, ext_vsync_i, ext_hsync_i}),
    .q_o   (ext_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_prev_q <= SYNC_RST[0];
      vs_prev_q <= SYNC_RST[1];
    end else begin
      hs_prev_q <= ext_lvl[0];
      vs_prev_q <= ext_lvl[1];
    end
  end

  assign hs_fall = hs_prev_q && !ext_lvl[0];
  assign vs_rise = !vs_prev_q && ext_lvl[1];

  logic h_realign, v_realign, line_start, vs_start, hs_act, vs_act;

  assign h_realign = slave_q && hs_fall;
  assign v_realign = slave_q && vs_rise;

  vsync_hcnt #(.W(HCNT_W)) u_hcnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .realign_i   (h_realign),
    .cyc_i       (hcyc_q),
    .wid_i       (hwid_q),
    .cnt_o       (hpos_o),
    .line_start_o(line_start),
    .act_o       (hs_act)
  );

  vsync_vcnt #(.W(VCNT_W)) u_vcnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .realign_i   (v_realign),
    .line_start_i(line_start),
    .cyc_i       (vcyc_q),
    .wid_i       (vwid_q),
    .sp_i        (vsp_q),
    .cnt_o       (vpos_o),
    .vs_start_o  (vs_start),
    .act_o       (vs_act)
  );

  vsync_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vs_start_i (vs_start),
    .clr_frame_i(clr_frame),
    .clr_vblk_i (clr_vblk),
    .slave_i    (slave_q),
    .ilace_i    (ilace_q),
    .field_ext_i(ext_lvl[2]),
    .frame_o    (frame_o),
    .vblank_o   (vblank_o),
    .field_gen_o(field_o),
    .field_odd_o(field_odd_o),
    .field_oe_o (field_oe_o)
  );

  assign hsync_o = slave_q || !hs_act;
  assign vsync_o = slave_q || !vs_act;
  assign csync_o = slave_q || (hsync_o && vsync_o);

  // R7
  hs_realign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_q && hs_fall) |=> (hpos_o == '0));

  // R8
  vs_realign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_q && vs_rise) |=> (vpos_o == '0));

  // R9
  slave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_q |-> (csync_o && hsync_o && vsync_o));
endmodule

// File: tb/vsync_gen_tb.sv
module vsync_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [11:0] wdata = '0;
  logic        ext_hs = 1'b1, ext_vs = 1'b0, fld_in = 1'b0;
  logic        hsync, vsync, csync, fld_o, fld_oe, fld_odd, frame, vblank;
  logic [11:0] hpos;
  logic [10:0] vpos;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vsync_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .ext_hsync_i(ext_hs), .ext_vsync_i(ext_vs), .field_i(fld_in),
    .hsync_o(hsync), .vsync_o(vsync), .csync_o(csync), .field_o(fld_o),
    .field_oe_o(fld_oe), .field_odd_o(fld_odd), .frame_o(frame), .vblank_o(vblank),
    .hpos_o(hpos), .vpos_o(vpos)
  );

  typedef struct packed { int hc; int hw; int vc; int vw; int vsp; } vec_t;
  localparam vec_t VECS [3] = '{
    '{hc: 12, hw: 3, vc: 8,  vw: 2, vsp: 3},
    '{hc: 25, hw: 1, vc: 5,  vw: 1, vsp: 0},
    '{hc: 7,  hw: 6, vc: 12, vw: 4, vsp: 8}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = 12'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic cfg(input int hc, input int hw, input int vc, input int vw, input int vsp);
    wr(3'd2, hc); wr(3'd1, hw); wr(3'd4, vc); wr(3'd3, vw); wr(3'd5, vsp);
  endtask

  function automatic logic sig(input bit v);
    return v ? vsync : hsync;
  endfunction

  // wait for a falling edge of the chosen sync, return low width and fall-to-fall period
  task automatic measure(input bit v, output int low, output int per);
    while (sig(v) !== 1'b1) @(negedge clk);
    while (sig(v) !== 1'b0) @(negedge clk);
    low = 0;
    while (sig(v) === 1'b0) begin low++; @(negedge clk); end
    per = low;
    while (sig(v) === 1'b1) begin per++; @(negedge clk); end
  endtask

  task automatic wait_vfall();
    while (vsync !== 1'b1) @(negedge clk);
    while (vsync !== 1'b0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lo, per, bad, p, v;
    logic f1;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(hpos == 0, "R1 hpos", int'(hpos), 0);
    chk(vpos == 0, "R1 vpos", int'(vpos), 0);
    chk({frame, vblank} == 2'b00, "R1 flags", int'({frame, vblank}), 0);
    chk({fld_odd, fld_oe} == 2'b00, "R1 field", int'({fld_odd, fld_oe}), 0);
    rst_n = 1'b1;

    // vector table: master timing R2 R3 R4
    foreach (VECS[i]) begin
      wr(3'd0, 0);
      cfg(VECS[i].hc, VECS[i].hw, VECS[i].vc, VECS[i].vw, VECS[i].vsp);
      measure(1'b0, lo, per);
      chk(lo == VECS[i].hw, "R2 hsync width", lo, VECS[i].hw);
      chk(per == VECS[i].hc, "R2 hsync period", per, VECS[i].hc);
      measure(1'b1, lo, per);
      chk(lo == VECS[i].vw * VECS[i].hc, "R3 vsync width", lo, VECS[i].vw * VECS[i].hc);
      chk(per == VECS[i].vc * VECS[i].hc, "R3 vsync period", per, VECS[i].vc * VECS[i].hc);
      wait_vfall();
      chk(int'(vpos) == VECS[i].vsp, "R3 vsync start line", int'(vpos), VECS[i].vsp);
      bad = 0;
      for (int k = 0; k < 2 * VECS[i].vc * VECS[i].hc; k++) begin
        if (csync !== (hsync & vsync)) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R4 csync", bad, 0);
    end

    // R5 R6 flags in master mode
    cfg(10, 2, 6, 1, 2);
    while (vpos != 1) @(negedge clk);
    wr(3'd6, 3);
    chk({frame, vblank} == 2'b00, "R6 clear both", int'({frame, vblank}), 0);
    while (vpos != 2) @(negedge clk);
    chk({frame, vblank} == 2'b11, "R5 set at vsp", int'({frame, vblank}), 3);
    wr(3'd6, 1);
    chk({frame, vblank} == 2'b01, "R6 clear frame only", int'({frame, vblank}), 1);
    wr(3'd6, 2);
    chk({frame, vblank} == 2'b00, "R6 clear vblank", int'({frame, vblank}), 0);

    // R10 master interlace
    wr(3'd0, 2);
    wait_vfall();
    f1 = fld_odd;
    chk(fld_oe == 1'b1, "R10 field_oe", int'(fld_oe), 1);
    chk(fld_o == fld_odd, "R10 field_o", int'(fld_o), int'(fld_odd));
    wait_vfall();
    chk(fld_odd == !f1, "R10 field toggle", int'(fld_odd), int'(!f1));

    // R12 non-interlace ignores field input
    wr(3'd0, 0);
    fld_in = 1'b1;
    bad = 0;
    for (int k = 0; k < 200; k++) begin
      if (fld_odd !== 1'b0 || fld_oe !== 1'b0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R12 master field ignored", bad, 0);
    wr(3'd0, 1);
    repeat (5) @(negedge clk);
    chk({fld_odd, fld_oe} == 2'b00, "R12 slave field ignored", int'({fld_odd, fld_oe}), 0);
    fld_in = 1'b0;

    // slave mode
    cfg(100, 4, 10, 1, 2);
    while (hpos < 5 || hpos > 80) @(negedge clk);
    ext_hs = 1'b0;
    repeat (3) @(negedge clk);
    chk(hpos == 0, "R7 hsync fall realign", int'(hpos), 0);
    p = int'(hpos);
    ext_hs = 1'b1;
    repeat (3) @(negedge clk);
    chk(int'(hpos) == p + 3, "R7 hsync rise ignored", int'(hpos), p + 3);

    while (vpos != 3 || hpos > 80) @(negedge clk);
    ext_vs = 1'b1;
    repeat (3) @(negedge clk);
    chk(vpos == 0, "R8 vsync rise realign", int'(vpos), 0);
    v = int'(vpos);
    ext_vs = 1'b0;
    repeat (3) @(negedge clk);
    chk(int'(vpos) == v, "R8 vsync fall ignored", int'(vpos), v);
    wr(3'd6, 3);
    chk({frame, vblank} == 2'b00, "R6 slave clear", int'({frame, vblank}), 0);
    while (vpos != 2) @(negedge clk);
    chk({frame, vblank} == 2'b11, "R5 slave set at vsp", int'({frame, vblank}), 3);

    bad = 0;
    for (int k = 0; k < 300; k++) begin
      if ({csync, hsync, vsync} !== 3'b111) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9 slave syncs high", bad, 0);

    // R11 slave interlace follows field input
    wr(3'd0, 3);
    fld_in = 1'b1;
    repeat (2) @(negedge clk);
    chk(fld_odd == 1'b1, "R11 field follows high", int'(fld_odd), 1);
    chk(fld_oe == 1'b0, "R11 field_oe low", int'(fld_oe), 0);
    fld_in = 1'b0;
    repeat (2) @(negedge clk);
    chk(fld_odd == 1'b0, "R11 field follows low", int'(fld_odd), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule